// File: doc/BRIEF.md
# Interrupt Mask and Pending Register Pair

This block holds a 32-bit interrupt enable mask and a 32-bit pending register, both reachable through a simple register access port. It watches a vector of interrupt lines and records each low-to-high transition as a pending bit. It combines pending and enabled bits into one interrupt request for the core.

Software reaches both registers by a 16-bit register number, formed as group times 2048 plus an index within the group. The pair sits in group 9. The enable mask is at index 0, so its number is 0x4800. The pending register is at index 1, so its number is 0x4801. A write to the mask can only turn enable bits on. A write to the pending register can only turn pending bits off. Reads return the register contents on the same cycle. Vector selection, priority and exception entry belong to the core and are not part of this block.

Top module: `irq_mask_stat`

## Requirements
- R1: After reset, both the mask and the pending register read as 0, and `irq_req` is 0.
- R2: A write (`acc_en`=1, `acc_we`=1) to register number 0x4800 sets the new mask to the old mask OR `acc_wdata`. The update is visible after the next rising clock edge. A mask write never clears a mask bit.
- R3: A write to register number 0x4801 clears every pending bit whose `acc_wdata` bit is 1. Pending bits whose data bit is 0 are left as they are.
- R4: When `acc_en`=1 and `acc_we`=0, `acc_rdata` returns the mask for number 0x4800 and the pending register for 0x4801. It returns 0 for any other number, and 0 when `acc_en`=0.
- R5: A rising transition on `irq_in[i]` between two clock edges sets pending bit i at the second edge. A line held high does not set its bit again after software clears it.
- R6: If a rising transition and a software clear hit the same pending bit on the same edge, the bit ends up set.
- R7: `irq_req` is 1 exactly when some bit is set in both the pending register and the mask.
- R8: A write to any other register number, or any access with `acc_en`=0, changes neither register. A mask write leaves the pending register unchanged, and a pending-register write leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Register access valid this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 16 | Register number (group*2048 + index) |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational |
| irq_in | input | 32 | Level interrupt lines |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
The embedded assertions check several rules on every cycle: enable bits never fall, the mask only changes on a decoded mask write, and pending bits fall only where a clear was requested. They also check that every detected rising edge lands in the pending register, and that the request is never raised with an empty mask. The bench scenarios cover the rest. These include the exact OR and clear arithmetic over whole data patterns, the read mux and its zero result for unmapped numbers, and the set-beats-clear collision. They also cover the rule that a held line does not set its bit again, and a sweep that relates each line to the request under a partial mask.

// File: rtl/irq_mask_stat_pkg.sv
package irq_mask_stat_pkg;

    // Which architected register an access selects.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_PEND = 2'd2
    } irq_sel_e;

    // Register number from group and index within group.
    function automatic logic [15:0] reg_number(input int unsigned group,
                                               input int unsigned index,
                                               input int unsigned shift);
        reg_number = 16'((group << shift) + index);
    endfunction

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int unsigned LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines_i,
    output logic [LINES-1:0] rise_o
);

    typedef struct packed {
        logic [LINES-1:0] prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lines_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // While held in reset no edge is reported.
    assign rise_o = rst_n ? (lines_i & ~st_q.prev) : '0;

endmodule

// File: rtl/irq_access_decode.sv
module irq_access_decode
    import irq_mask_stat_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned GROUP     = 9,
    parameter int unsigned GRP_SHIFT = 11,
    parameter int unsigned MASK_IDX  = 0,
    parameter int unsigned PEND_IDX  = 1
) (
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output irq_sel_e          sel_o,
    output logic [DATA_W-1:0] mask_set_o,
    output logic [DATA_W-1:0] pend_clr_o
);

    localparam logic [ADDR_W-1:0] MASK_NUM = ADDR_W'(reg_number(GROUP, MASK_IDX, GRP_SHIFT));
    localparam logic [ADDR_W-1:0] PEND_NUM = ADDR_W'(reg_number(GROUP, PEND_IDX, GRP_SHIFT));

    always_comb begin
        sel_o = SEL_NONE;
        if (acc_en) begin
            if (acc_addr == MASK_NUM) begin
                sel_o = SEL_MASK;
            end else if (acc_addr == PEND_NUM) begin
                sel_o = SEL_PEND;
            end
        end
    end

    always_comb begin
        mask_set_o = '0;
        pend_clr_o = '0;
        if (acc_we) begin
            if (sel_o == SEL_MASK) begin
                mask_set_o = acc_wdata;
            end
            if (sel_o == SEL_PEND) begin
                pend_clr_o = acc_wdata;
            end
        end
    end

endmodule

// File: rtl/irq_mask_stat.sv
module irq_mask_stat
    import irq_mask_stat_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned GROUP     = 9,
    parameter int unsigned GRP_SHIFT = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic [DATA_W-1:0] irq_in,
    output logic              irq_req
);

    localparam int unsigned LINES = DATA_W;

    typedef struct packed {
        logic [LINES-1:0] mask;
        logic [LINES-1:0] pend;
    } ctrl_state_t;

    ctrl_state_t      st_d, st_q;
    irq_sel_e         sel;
    logic [LINES-1:0] mask_set;
    logic [LINES-1:0] pend_clr;
    logic [LINES-1:0] rise;

    irq_access_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .GROUP    (GROUP),
        .GRP_SHIFT(GRP_SHIFT),
        .MASK_IDX (0),
        .PEND_IDX (1)
    ) u_decode (
        .acc_en    (acc_en),
        .acc_we    (acc_we),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .sel_o     (sel),
        .mask_set_o(mask_set),
        .pend_clr_o(pend_clr)
    );

    irq_edge_detect #(
        .LINES(LINES)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lines_i(irq_in),
        .rise_o (rise)
    );

    // Next state: enables only accumulate; pending clear first, then edges set.
    always_comb begin
        st_d      = st_q;
        st_d.mask = st_q.mask | mask_set;
        st_d.pend = (st_q.pend & ~pend_clr) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        acc_rdata = '0;
        if (!acc_we) begin
            case (sel)
                SEL_MASK: acc_rdata = st_q.mask;
                SEL_PEND: acc_rdata = st_q.pend;
                default:  acc_rdata = '0;
            endcase
        end
    end

    assign irq_req = |(st_q.pend & st_q.mask);

    // R2: an enable bit once set stays set.
    a_r2_mask_never_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask & $past(st_q.mask)) == $past(st_q.mask));

    // R8: the mask moves only after a decoded mask write.
    a_r8_mask_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel) != SEL_MASK) |-> $stable(st_q.mask));

    // R3: a pending bit falls only where a clear was requested.
    a_r3_pend_falls_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n)) |-> ((($past(st_q.pend) & ~st_q.pend) & ~$past(pend_clr)) == '0));

    // R5/R6: every detected edge is recorded, regardless of a clear.
    a_r6_rise_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n)) |-> ((st_q.pend & $past(rise)) == $past(rise)));

    // R7: no request without an enabled line.
    a_r7_req_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (st_q.mask != '0 && st_q.pend != '0));

endmodule

// File: tb/irq_mask_stat_bench.sv
`timescale 1ns/1ps
module irq_mask_stat_bench;

    localparam logic [15:0] A_MASK = 16'h4800;
    localparam logic [15:0] A_PEND = 16'h4801;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_we = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [31:0] irq_in = '0;
    logic        irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_mask = '0;
    logic [31:0] m_pend = '0;
    logic [31:0] m_prev = '0;

    always #2.5 clk = ~clk;

    irq_mask_stat u_irq_mask_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en   (acc_en),
        .acc_we   (acc_we),
        .acc_addr (acc_addr),
        .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata),
        .irq_in   (irq_in),
        .irq_req  (irq_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, update model, step to next falling edge.
    task automatic cycle(input logic en, input logic we, input logic [15:0] addr,
                         input logic [31:0] wd, input logic [31:0] lines);
        logic [31:0] rise_v;
        logic [31:0] clr_v;
        acc_en = en; acc_we = we; acc_addr = addr; acc_wdata = wd; irq_in = lines;
        rise_v = lines & ~m_prev;
        clr_v  = (en && we && addr == A_PEND) ? wd : 32'h0;
        if (en && we && addr == A_MASK) m_mask = m_mask | wd;
        m_pend = (m_pend & ~clr_v) | rise_v;
        m_prev = lines;
        @(posedge clk);
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic read_reg(input logic [15:0] addr, output logic [31:0] val);
        acc_en = 1'b1; acc_we = 1'b0; acc_addr = addr;
        #1;
        val = acc_rdata;
        acc_en = 1'b0;
        #1;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        read_reg(A_MASK, v);
        check({tag, " mask"}, v, m_mask);
        read_reg(A_PEND, v);
        check({tag, " pend"}, v, m_pend);
        check({tag, " R7 req"}, {31'h0, irq_req}, {31'h0, |(m_mask & m_pend)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");

        // R5: each line's rising edge sets its own pending bit only.
        for (int i = 0; i < 32; i++) begin
            cycle(1'b0, 1'b0, 16'h0, 32'h0, 32'h1 << i);
            check_all($sformatf("R5 rise line %0d", i));
            cycle(1'b0, 1'b0, 16'h0, 32'h0, 32'h0);
        end
        check("R5 all pending", m_pend, 32'hFFFF_FFFF);

        // R2: mask writes accumulate; writing zero clears nothing.
        cycle(1'b1, 1'b1, A_MASK, 32'h0000_00F0, 32'h0);
        check_all("R2 first set");
        cycle(1'b1, 1'b1, A_MASK, 32'h0F00_0000, 32'h0);
        check_all("R2 or set");
        cycle(1'b1, 1'b1, A_MASK, 32'h0000_0000, 32'h0);
        check_all("R2 zero write");
        check("R2 mask value", m_mask, 32'h0F00_00F0);

        // R3: write-one-to-clear with several patterns.
        cycle(1'b1, 1'b1, A_PEND, 32'h5555_5555, 32'h0);
        check_all("R3 clear 5555");
        cycle(1'b1, 1'b1, A_PEND, 32'h0000_0000, 32'h0);
        check_all("R3 clear none");
        cycle(1'b1, 1'b1, A_PEND, 32'hA000_00A0, 32'h0);
        check_all("R3 clear partial");

        // R8: ignored accesses.
        cycle(1'b1, 1'b1, 16'h4802, 32'hFFFF_FFFF, 32'h0);
        check_all("R8 other index");
        cycle(1'b1, 1'b1, 16'h0800, 32'hFFFF_FFFF, 32'h0);
        check_all("R8 other group");
        cycle(1'b0, 1'b1, A_MASK, 32'hFFFF_FFFF, 32'h0);
        check_all("R8 en low mask");
        cycle(1'b0, 1'b1, A_PEND, 32'hFFFF_FFFF, 32'h0);
        check_all("R8 en low pend");

        // R4: unmapped and idle reads return zero.
        read_reg(16'h4802, v);
        check("R4 unmapped read", v, 32'h0);
        acc_en = 1'b0; acc_we = 1'b0; acc_addr = A_PEND; #1;
        check("R4 idle read", acc_rdata, 32'h0);

        // R5: a held line does not set its bit again after a clear.
        cycle(1'b1, 1'b1, A_PEND, 32'hFFFF_FFFF, 32'h0);
        cycle(1'b0, 1'b0, 16'h0, 32'h0, 32'h0000_0010);
        check_all("R5 held rise");
        cycle(1'b1, 1'b1, A_PEND, 32'h0000_0010, 32'h0000_0010);
        check_all("R5 held cleared");
        cycle(1'b0, 1'b0, 16'h0, 32'h0, 32'h0000_0010);
        check("R5 held stays clear", m_pend & 32'h10, 32'h0);
        check_all("R5 held idle");

        // R6: rise and clear on the same bit in the same cycle.
        cycle(1'b0, 1'b0, 16'h0, 32'h0, 32'h0);
        cycle(1'b1, 1'b1, A_PEND, 32'h0000_0020, 32'h0000_0020);
        read_reg(A_PEND, v);
        check("R6 set wins", v & 32'h20, 32'h20);
        check_all("R6 state");
        cycle(1'b1, 1'b1, A_PEND, 32'hFFFF_FFFF, 32'h0);

        // R7: each line against the partial mask.
        for (int i = 0; i < 32; i++) begin
            cycle(1'b0, 1'b0, 16'h0, 32'h0, 32'h1 << i);
            check($sformatf("R7 line %0d", i), {31'h0, irq_req},
                  {31'h0, ((32'h0F00_00F0 >> i) & 32'h1) != 0});
            cycle(1'b1, 1'b1, A_PEND, 32'hFFFF_FFFF, 32'h0);
            check_all($sformatf("R7 cleared %0d", i));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule